// File: doc/BRIEF.md
# Bus Controller Message Gap Timer

This block paces a serial bus controller from one message to the next. The host selects the frequency of the system clock with a 2-bit code, and the block divides that clock down to an exact one-microsecond time base. It also receives a programmed message-start period, counted in microseconds. The sequencer pulses `msg_start` when a message begins and pulses `msg_end` when the message has finished on the wire. From these pulses the block decides the earliest cycle at which the following message may begin, and it signals that cycle by raising `start_next`.

The period runs from the start of one message to the start of the next, so it includes the message itself. A minimum idle gap after the end of every message is always kept, and this gap is longer when the enhanced sequencing mode is selected. The host may enable a stretch option. When the option is on, each host access that collides with one of the controller's internal start-of-message or end-of-message memory transfer slots adds a fixed number of clock cycles to the gap. Each slot counts at most once per message.

Top module: `msg_gap_timer`

## Requirements
- R1: `rate_sel` sets the number of clock cycles in one microsecond: code 0 gives 10, code 1 gives 12, code 2 gives 16 and code 3 gives 20.
- R2: The microsecond count begins at the `msg_start` edge. `start_next` cannot rise until at least `period_us` × cycles-per-µs clock edges have passed since that edge.
- R3: A `period_us` of zero imposes no period limit, so only the minimum gap and any stretch apply.
- R4: Counting from the edge that samples `msg_end`, `start_next` stays low for at least MIN_GAP_CYC clock edges.
- R5: While `enh_mode` is high, the minimum gap becomes MIN_GAP_CYC + ENH_EXTRA cycles.
- R6: While `stretch_en` is high and a message is in progress, a high bit on `som_hit` (7 slots) or `eom_hit` (5 slots) adds PENALTY cycles, which is 6 by default. Each slot counts at most once per message, so the worst case is 72 cycles. Strobes sampled on the `msg_start` edge are not counted.
- R7: While `stretch_en` is low, collision strobes add no delay.
- R8: The accumulated stretch is served only after both the period and the minimum gap have expired. `start_next` rises on the edge max(m + gap, period × cycles-per-µs) + 1 + stretch after the `msg_start` edge, where m is the number of edges from that edge to the `msg_end` edge.
- R9: `start_next` stays high until the next `msg_start`. A `msg_start` in any state drops `start_next` on that edge and restarts all timing from zero.
- R10: `rate_sel` is sampled only on edges where no message is in progress, so a change made during a message has no effect on that message.
- R11: While `rst_n` is low, `start_next` is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Clock frequency code (0:10, 1:12, 2:16, 3:20 MHz) |
| period_us | input | PERIOD_W | Message-start period in µs, 0 = minimum gap only |
| enh_mode | input | 1 | Enhanced sequencing mode, which lengthens the minimum gap |
| stretch_en | input | 1 | Enables the collision stretch |
| msg_start | input | 1 | Sequencer pulse: a message begins |
| msg_end | input | 1 | Sequencer pulse: the message has finished |
| som_hit | input | SOM_N | Host collision strobes, one per start-of-message transfer slot |
| eom_hit | input | EOM_N | Host collision strobes, one per end-of-message transfer slot |
| start_next | output | 1 | The next message may start |

## Verification
The bench builds the block with MIN_GAP_CYC = 8, and leaves ENH_EXTRA = 10, PENALTY = 6 and the 7 + 5 slot counts at their defaults. The shortened minimum gap makes the gap-bound and period-bound regimes both reachable within a few dozen cycles at every clock-rate code. The full 72-cycle worst-case stretch, repeated strobes on the same slot, and one period of 1500 µs at 16 cycles per µs also fit within the run.

// File: rtl/gap_pkg.sv
package gap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MSG  = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } gap_state_e;

  localparam int RATE_W = 2;
  localparam int PRE_W  = 5;

  // cycles per microsecond minus one, for each clock-rate code
  function automatic logic [PRE_W-1:0] cyc_per_us_m1(input logic [RATE_W-1:0] code);
    logic [PRE_W-1:0] r;
    case (code)
      2'd0:    r = PRE_W'(9);
      2'd1:    r = PRE_W'(11);
      2'd2:    r = PRE_W'(15);
      default: r = PRE_W'(19);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gap_prescaler.sv
module gap_prescaler #(
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] div_m1,
  output logic             tick
);

  logic [PRE_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run)
      cnt_d = tick ? '0 : cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // R1
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div_m1));

  // R1
  pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (cnt_q == '0));

endmodule

// File: rtl/gap_stretch.sv
module gap_stretch #(
  parameter int SOM_N   = 7,
  parameter int EOM_N   = 5,
  parameter int PENALTY = 6,
  localparam int MAX_ST = PENALTY * (SOM_N + EOM_N),
  localparam int SW     = $clog2(MAX_ST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             accept,
  input  logic             enable,
  input  logic [SOM_N-1:0] som_hit,
  input  logic [EOM_N-1:0] eom_hit,
  input  logic             dec,
  output logic [SW-1:0]    left
);

  logic [SOM_N-1:0] som_seen_q, som_seen_d, som_new;
  logic [EOM_N-1:0] eom_seen_q, eom_seen_d, eom_new;
  logic [SW-1:0]    left_q, left_d, add_c;
  int               n_new;

  assign som_new = som_hit & ~som_seen_q & {SOM_N{accept && enable}};
  assign eom_new = eom_hit & ~eom_seen_q & {EOM_N{accept && enable}};
  assign left    = left_q;

  always_comb begin
    n_new      = $countones(som_new) + $countones(eom_new);
    add_c      = SW'(PENALTY * n_new);
    som_seen_d = som_seen_q | som_new;
    eom_seen_d = eom_seen_q | eom_new;
    left_d     = left_q + add_c - SW'(dec);
    if (clr) begin
      som_seen_d = '0;
      eom_seen_d = '0;
      left_d     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      som_seen_q <= '0;
      eom_seen_q <= '0;
      left_q     <= '0;
    end else begin
      som_seen_q <= som_seen_d;
      eom_seen_q <= eom_seen_d;
      left_q     <= left_d;
    end
  end

  // R6
  stretch_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= SW'(MAX_ST));

  // R7
  no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (left_q <= $past(left_q)));

endmodule

// File: rtl/msg_gap_timer.sv
module msg_gap_timer
  import gap_pkg::*;
#(
  parameter int MIN_GAP_CYC = 40,
  parameter int ENH_EXTRA   = 10,
  parameter int PENALTY     = 6,
  parameter int SOM_N       = 7,
  parameter int EOM_N       = 5,
  parameter int PERIOD_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          rate_sel,
  input  logic [PERIOD_W-1:0] period_us,
  input  logic                enh_mode,
  input  logic                stretch_en,
  input  logic                msg_start,
  input  logic                msg_end,
  input  logic [SOM_N-1:0]    som_hit,
  input  logic [EOM_N-1:0]    eom_hit,
  output logic                start_next
);

  localparam int GAP_MAX = MIN_GAP_CYC + ENH_EXTRA;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int SW      = $clog2(PENALTY * (SOM_N + EOM_N) + 1);

  gap_state_e          state_q, state_d;
  logic [RATE_W-1:0]   rate_q, rate_d;
  logic [PERIOD_W-1:0] us_q, us_d;
  logic [GAP_W-1:0]    gap_q, gap_d, gap_need;
  logic [SW-1:0]       st_left;
  logic                busy, tick, period_ok, gap_ok, base_ok, st_dec;

  assign busy      = (state_q == ST_MSG) || (state_q == ST_GAP);
  assign gap_need  = enh_mode ? GAP_W'(GAP_MAX) : GAP_W'(MIN_GAP_CYC);
  assign period_ok = (us_q >= period_us);
  assign gap_ok    = (gap_q >= gap_need);
  assign base_ok   = (state_q == ST_GAP) && gap_ok && period_ok;
  assign st_dec    = base_ok && (st_left != '0) && !msg_start;

  gap_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (msg_start),
    .run    (busy && !msg_start),
    .div_m1 (cyc_per_us_m1(rate_q)),
    .tick   (tick)
  );

  gap_stretch #(
    .SOM_N   (SOM_N),
    .EOM_N   (EOM_N),
    .PENALTY (PENALTY)
  ) u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (msg_start),
    .accept  (busy && !msg_start),
    .enable  (stretch_en),
    .som_hit (som_hit),
    .eom_hit (eom_hit),
    .dec     (st_dec),
    .left    (st_left)
  );

  always_comb begin
    state_d = state_q;
    rate_d  = rate_q;
    us_d    = us_q;
    gap_d   = gap_q;
    if (!busy)
      rate_d = rate_sel;
    if (msg_start) begin
      state_d = ST_MSG;
      us_d    = '0;
      gap_d   = '0;
    end else begin
      if (busy && tick && (us_q != '1))
        us_d = us_q + PERIOD_W'(1);
      case (state_q)
        ST_MSG: begin
          if (msg_end) begin
            state_d = ST_GAP;
            gap_d   = '0;
          end
        end
        ST_GAP: begin
          if (!gap_ok)
            gap_d = gap_q + GAP_W'(1);
          if (base_ok && (st_left == '0))
            state_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rate_q  <= '0;
      us_q    <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      rate_q  <= rate_d;
      us_q    <= us_d;
      gap_q   <= gap_d;
    end
  end

  assign start_next = (state_q == ST_DONE);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_next && !msg_start) |=> start_next);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> !start_next);

  // R10
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rate_q));

  // R2
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_next) |-> $past(us_q >= period_us));

  // R4
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_next) |-> ($past(gap_q) >= $past(gap_need)));

endmodule

// File: tb/test_msg_gap_timer.sv
`timescale 1ns/1ps
module test_msg_gap_timer;

  localparam int MIN_GAP = 8;
  localparam int EXTRA   = 10;
  localparam int PEN     = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  rate_sel;
  logic [15:0] period_us;
  logic        enh_mode, stretch_en, msg_start, msg_end;
  logic [6:0]  som_hit;
  logic [4:0]  eom_hit;
  logic        start_next;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  msg_gap_timer #(
    .MIN_GAP_CYC (MIN_GAP),
    .ENH_EXTRA   (EXTRA),
    .PENALTY     (PEN)
  ) i_msg_gap_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .period_us  (period_us),
    .enh_mode   (enh_mode),
    .stretch_en (stretch_en),
    .msg_start  (msg_start),
    .msg_end    (msg_end),
    .som_hit    (som_hit),
    .eom_hit    (eom_hit),
    .start_next (start_next)
  );

  function automatic int div_of(input logic [1:0] c);
    case (c)
      2'd0: return 10;
      2'd1: return 12;
      2'd2: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, updated on every edge
  int       m_t, m_end, m_s, m_div;
  bit       m_started, m_ended, m_out;
  bit [6:0] m_ss;
  bit [4:0] m_es;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_end = 0; m_s = 0; m_div = 10;
      m_started = 0; m_ended = 0; m_out = 0; m_ss = '0; m_es = '0;
    end else begin
      bit bz;
      int mg;
      bz = m_started && !m_out;
      if (msg_start) begin
        if (!bz) m_div = div_of(rate_sel);
        m_started = 1; m_ended = 0; m_t = 0; m_s = 0; m_ss = '0; m_es = '0;
      end else if (bz) begin
        m_t++;
        if (msg_end && !m_ended) begin
          m_ended = 1;
          m_end   = m_t;
        end
        if (stretch_en) begin
          for (int i = 0; i < 7; i++)
            if (som_hit[i] && !m_ss[i]) begin m_s += PEN; m_ss[i] = 1; end
          for (int i = 0; i < 5; i++)
            if (eom_hit[i] && !m_es[i]) begin m_s += PEN; m_es[i] = 1; end
        end
      end
      mg = MIN_GAP + (enh_mode ? EXTRA : 0);
      m_out = m_started && m_ended &&
              (m_t >= imax(m_end + mg, int'(period_us) * m_div) + 1 + m_s);
    end
  end

  // R8: cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1)
      chk(start_next === m_out, "R8 cycle model", int'(start_next), int'(m_out));
  end

  // one message; measures edges from the msg_start edge to start_next
  task automatic run_case(input logic [1:0] rate, input logic [1:0] rate2,
                          input int per, input int m,
                          input logic [6:0] som, input logic [4:0] eom,
                          input logic sen, input logic enh, input string tag);
    int d, s, mg, seen_t;
    s  = sen ? PEN * ($countones(som) + $countones(eom)) : 0;
    mg = MIN_GAP + (enh ? EXTRA : 0);
    d  = imax(m + mg, per * div_of(rate)) + 1 + s;
    rate_sel = rate; period_us = 16'(per); stretch_en = sen; enh_mode = enh;
    msg_start = 1'b1;
    @(negedge clk);
    msg_start = 1'b0;
    seen_t = -1;
    for (int t = 0; t < d + 50; t++) begin
      if (start_next) begin seen_t = t; break; end
      som_hit  = (t == 0 || t == 2) ? som : '0;
      eom_hit  = (t == 1) ? eom : '0;
      msg_end  = (t + 1 == m);
      rate_sel = (t >= 1) ? rate2 : rate;
      @(negedge clk);
    end
    som_hit = '0; eom_hit = '0; msg_end = 1'b0;
    chk(seen_t == d, tag, seen_t, d);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rate_sel = '0; period_us = '0; enh_mode = 0; stretch_en = 0;
    msg_start = 0; msg_end = 0; som_hit = '0; eom_hit = '0;
    repeat (3) @(negedge clk);
    // R11
    chk(start_next == 1'b0, "R11 reset state", int'(start_next), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(start_next == 1'b0, "R11 idle after reset", int'(start_next), 0);

    // R1: period-bound at each rate code
    run_case(2'd0, 2'd0, 3, 4, '0, '0, 0, 0, "R1 rate 10");
    run_case(2'd1, 2'd1, 3, 4, '0, '0, 0, 0, "R1 rate 12");
    run_case(2'd2, 2'd2, 3, 4, '0, '0, 0, 0, "R1 rate 16");
    run_case(2'd3, 2'd3, 3, 4, '0, '0, 0, 0, "R1 rate 20");
    // R2: long period
    run_case(2'd2, 2'd2, 1500, 30, '0, '0, 0, 0, "R2 long period");
    // R3: zero period
    run_case(2'd0, 2'd0, 0, 5, '0, '0, 0, 0, "R3 zero period");
    // R4: gap-bound despite a period
    run_case(2'd0, 2'd0, 1, 20, '0, '0, 0, 0, "R4 gap bound");
    // R5: enhanced mode
    run_case(2'd0, 2'd0, 0, 5, '0, '0, 0, 1, "R5 enhanced gap");
    // R6: some slots, repeated strobes count once
    run_case(2'd0, 2'd0, 0, 5, 7'b0000101, 5'b10001, 1, 0, "R6 partial stretch");
    // R6/R8: worst case 72 after period
    run_case(2'd3, 2'd3, 2, 4, 7'h7F, 5'h1F, 1, 0, "R6 R8 worst stretch");
    // R7: strobes ignored when disabled
    run_case(2'd0, 2'd0, 0, 5, 7'h7F, 5'h1F, 0, 0, "R7 stretch disabled");
    // R10: rate change mid-message ignored
    run_case(2'd0, 2'd3, 2, 4, '0, '0, 0, 0, "R10 rate frozen");

    // R9: hold until next start
    begin
      int held;
      held = 0;
      for (int i = 0; i < 20; i++) begin
        if (start_next) held++;
        @(negedge clk);
      end
      chk(held == 20, "R9 hold", held, 20);
    end

    // R9: restart while a message is in progress
    rate_sel = 2'd0; period_us = '0; msg_start = 1'b1;
    @(negedge clk);
    msg_start = 1'b0;
    chk(start_next == 1'b0, "R9 drop on start", int'(start_next), 0);
    repeat (3) @(negedge clk);
    run_case(2'd0, 2'd0, 0, 6, '0, '0, 0, 0, "R9 restart");

    // R11: reset in mid-message
    rate_sel = 2'd1; period_us = 16'd5; msg_start = 1'b1;
    @(negedge clk);
    msg_start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(start_next == 1'b0, "R11 reset mid-run", int'(start_next), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(2'd0, 2'd0, 0, 5, '0, '0, 0, 0, "R11 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule